// File: doc/BRIEF.md
# Adaptive Biphase (F2F) Bit Recovery

This block turns a stream of flux-transition events into decoded data bits for a magnetic-stripe read channel. Each event arrives as a one-cycle strobe with a timestamp taken from a free-running counter. The block looks only at the spacing between events. The polarity of a transition plays no part, and no fixed bit clock is assumed. A cell with no transition inside it is a 0. A cell split by an extra transition in the middle is a 1.

A stripe starts with a run of zeros. The block first waits for a run of evenly spaced intervals and takes their average as its first estimate of the cell length. From then on it updates that estimate after every decoded bit, so it can follow a hand swipe that speeds up or slows down by about twenty to one. Two faults drop synchronisation and raise an error pulse: an interval too long to be a cell, and a half-cell with no matching second half. After either fault the block hunts for a fresh run of even intervals before it decodes again. Character framing, parity and longitudinal checks belong to later stages.

Top module: `f2f_bit_recover`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `bit_strobe`, `bit_data`, `sync_lock` and `bit_err` are all 0.
- R2: The interval of an event is its timestamp minus the timestamp of the previous event, modulo 2^STAMP_W, so a counter wrap is harmless. The first event after reset only sets the reference and forms no interval.
- R3: When unlocked, an interval `b` extends the current run if the run is not empty and 4*|b-a| <= a, where `a` is the previous interval. Otherwise `b` starts a new run of length 1. `sync_lock` rises one cycle after the event that brings the run to 2^RUN_LOG2 intervals (default 8). No bit and no error is reported while hunting.
- R4: On lock, the cell period estimate P becomes floor(sum of the run's intervals / 2^RUN_LOG2).
- R5: While locked, an interval `t` is a half-cell when 4*t < 3*P. It is a full cell when 4*t >= 3*P and t <= 2*P. It is too long when t > 2*P.
- R6: A full cell with no half-cell pending gives `bit_data`=0. A second consecutive half-cell gives `bit_data`=1. In both cases `bit_strobe` is a single-cycle pulse one cycle after the event. The first half-cell of a pair reports nothing. `bit_data` is 0 whenever `bit_strobe` is 0.
- R7: After each decoded bit, P becomes P + floor((M - P)/4). M is the full-cell interval for a 0 and the sum of both halves for a 1. The operating range assumes P < 2^(STAMP_W-2).
- R8: A full cell arriving while a half-cell is pending gives a one-cycle `bit_err` pulse and clears `sync_lock` in the same cycle, with no bit.
- R9: A too-long interval gives a one-cycle `bit_err` pulse and clears `sync_lock` in the same cycle. An interval of exactly 2*P is still a 0.
- R10: After lock is lost, the event that caused the error becomes the new reference, and hunting starts over with the next interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flux_evt | input | 1 | One-cycle strobe marking a flux transition |
| flux_stamp | input | STAMP_W | Free-running counter value at the transition |
| bit_strobe | output | 1 | Decoded bit valid pulse |
| bit_data | output | 1 | Decoded bit value |
| sync_lock | output | 1 | Cell period acquired, decoding active |
| bit_err | output | 1 | One-cycle pulse when lock is lost on a bad interval |

## Verification
The bench builds the block with STAMP_W=12 and the default run length of 8. The narrow timestamp makes the counter wrap many times during a long swipe, while cell lengths from 50 to 1000 counts still fit below the 2^(STAMP_W-2) period limit. That span covers a twenty-to-one speed ramp, both up and down. With a period of 100, the half/full threshold and the near-equal hunt threshold fall on whole counts, so intervals of 75, 125 and 126 sit exactly on the decision edges. Faults are placed after the ramp, so the bench can also check relocking at a different speed.

// File: rtl/f2f_pkg.sv
// Shared helpers for the biphase bit recovery block.
// Assumes: interval and period values are unsigned counter differences.
package f2f_pkg;

    // Classification of one interval against the running cell period
    typedef enum logic [1:0] {
        CELL_HALF = 2'd0,
        CELL_FULL = 2'd1,
        CELL_LONG = 2'd2
    } cell_kind_e;

endpackage

// File: rtl/f2f_interval_meter.sv
// Converts timestamped transition events into intervals between consecutive events.
// Assumes: the stamp counter wraps at 2^STAMP_W and no real interval reaches that span.
module f2f_interval_meter #(
    parameter int STAMP_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               evt,
    input  logic [STAMP_W-1:0] stamp,
    output logic               iv_valid,
    output logic [STAMP_W-1:0] iv_len
);

    logic               have_ref_q;
    logic [STAMP_W-1:0] last_q;

    // Remember the stamp of the latest event as the next reference
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_ref_q <= 1'b0;
            last_q     <= '0;
        end else if (evt) begin
            have_ref_q <= 1'b1;
            last_q     <= stamp;
        end
    end

    // Modular difference gives the interval; the first event only sets the reference
    assign iv_valid = evt & have_ref_q;
    assign iv_len   = stamp - last_q;

endmodule

// File: rtl/f2f_sync_hunter.sv
// Searches for a run of near-equal intervals (the leading zeros) and reports
// their average as the initial cell period.
// Assumes: held idle (enable low) while the decoder is locked.
module f2f_sync_hunter #(
    parameter int STAMP_W  = 16,
    parameter int RUN_LOG2 = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               iv_valid,
    input  logic [STAMP_W-1:0] iv_len,
    output logic               found,
    output logic [STAMP_W-1:0] avg_period
);

    localparam int RUN_LEN = 1 << RUN_LOG2;
    localparam int CNT_W   = RUN_LOG2 + 1;
    localparam int SUM_W   = STAMP_W + RUN_LOG2;

    logic [CNT_W-1:0]   run_q, run_d;
    logic [SUM_W-1:0]   sum_q, sum_d;
    logic [STAMP_W-1:0] prev_q;
    logic [STAMP_W-1:0] gap;
    logic               near, extend;

    // Decide whether the new interval continues the current run
    always_comb begin
        gap    = (iv_len >= prev_q) ? (iv_len - prev_q) : (prev_q - iv_len);
        near   = {gap, 2'b00} <= {2'b00, prev_q};
        extend = (run_q != '0) && near;
        run_d  = extend ? (run_q + CNT_W'(1)) : CNT_W'(1);
        sum_d  = extend ? (sum_q + SUM_W'(iv_len)) : SUM_W'(iv_len);
    end

    assign found      = enable & iv_valid & (run_d == CNT_W'(RUN_LEN));
    assign avg_period = sum_d[SUM_W-1:RUN_LOG2];

    // Track run length, running sum and previous interval while hunting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            sum_q  <= '0;
            prev_q <= '0;
        end else if (!enable) begin
            run_q  <= '0;
        end else if (iv_valid) begin
            run_q  <= found ? '0 : run_d;
            sum_q  <= sum_d;
            prev_q <= iv_len;
        end
    end

endmodule

// File: rtl/f2f_cell_tracker.sv
// Classifies intervals against the running cell period, pairs half-cells into
// ones, reports faults and adapts the period after each decoded bit.
// Assumes: period stays below 2^(STAMP_W-2) so the update never wraps.
module f2f_cell_tracker
    import f2f_pkg::*;
#(
    parameter int STAMP_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [STAMP_W-1:0] load_period,
    input  logic               active,
    input  logic               iv_valid,
    input  logic [STAMP_W-1:0] iv_len,
    output logic               fire,
    output logic               value,
    output logic               fault
);

    localparam int WIDE_W = STAMP_W + 3;

    logic [STAMP_W-1:0]       period_q, half_q;
    logic                     pend_q;
    logic [STAMP_W+1:0]       three_p;
    cell_kind_e               kind;
    logic                     step;
    logic [STAMP_W:0]         meas;
    logic signed [WIDE_W-1:0] delta;
    logic [STAMP_W-1:0]       period_d;

    // Classify the interval as half, full or too long
    always_comb begin
        three_p = {1'b0, period_q, 1'b0} + {2'b00, period_q};
        if ({1'b0, iv_len} > {period_q, 1'b0})
            kind = CELL_LONG;
        else if ({iv_len, 2'b00} < three_p)
            kind = CELL_HALF;
        else
            kind = CELL_FULL;
    end

    // Decide the bit or fault outcome for this interval
    always_comb begin
        step  = active & iv_valid;
        fault = step & ((kind == CELL_LONG) | ((kind == CELL_FULL) & pend_q));
        fire  = step & ~fault & ((kind == CELL_FULL) | pend_q);
        value = fire & (kind == CELL_HALF);
    end

    // Next period: move a quarter of the way toward the measured cell length
    always_comb begin
        meas     = (kind == CELL_HALF) ? ({1'b0, half_q} + {1'b0, iv_len}) : {1'b0, iv_len};
        delta    = $signed({2'b00, meas}) - $signed({3'b000, period_q});
        period_d = STAMP_W'($signed({3'b000, period_q}) + (delta >>> 2));
    end

    // Hold period, pending half-cell flag and first-half length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= '0;
            half_q   <= '0;
            pend_q   <= 1'b0;
        end else if (load) begin
            period_q <= load_period;
            pend_q   <= 1'b0;
        end else if (step) begin
            if (fault) begin
                pend_q <= 1'b0;
            end else if (fire) begin
                period_q <= period_d;
                pend_q   <= 1'b0;
            end else begin
                pend_q <= 1'b1;
                half_q <= iv_len;
            end
        end
    end

endmodule

// File: rtl/f2f_bit_recover.sv
// Top of the biphase bit recovery block: measures intervals, hunts for sync on
// the leading zeros, then decodes bits with an adaptive cell period.
// Assumes: at most one transition event per clock, stamps from a free-running counter.
module f2f_bit_recover #(
    parameter int STAMP_W  = 16,
    parameter int RUN_LOG2 = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flux_evt,
    input  logic [STAMP_W-1:0] flux_stamp,
    output logic               bit_strobe,
    output logic               bit_data,
    output logic               sync_lock,
    output logic               bit_err
);

    logic               iv_valid;
    logic [STAMP_W-1:0] iv_len;
    logic               found;
    logic [STAMP_W-1:0] avg_period;
    logic               fire, value, fault;
    logic               lock_q, strobe_q, data_q, err_q;

    f2f_interval_meter #(.STAMP_W(STAMP_W)) u_meter (
        .clk(clk), .rst_n(rst_n), .evt(flux_evt), .stamp(flux_stamp),
        .iv_valid(iv_valid), .iv_len(iv_len)
    );

    f2f_sync_hunter #(.STAMP_W(STAMP_W), .RUN_LOG2(RUN_LOG2)) u_hunter (
        .clk(clk), .rst_n(rst_n), .enable(~lock_q),
        .iv_valid(iv_valid), .iv_len(iv_len),
        .found(found), .avg_period(avg_period)
    );

    f2f_cell_tracker #(.STAMP_W(STAMP_W)) u_tracker (
        .clk(clk), .rst_n(rst_n), .load(found), .load_period(avg_period),
        .active(lock_q), .iv_valid(iv_valid), .iv_len(iv_len),
        .fire(fire), .value(value), .fault(fault)
    );

    // Lock state and registered bit/error outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q   <= 1'b0;
            strobe_q <= 1'b0;
            data_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            if (found)
                lock_q <= 1'b1;
            else if (fault)
                lock_q <= 1'b0;
            strobe_q <= fire;
            data_q   <= value;
            err_q    <= fault;
        end
    end

    assign bit_strobe = strobe_q;
    assign bit_data   = data_q;
    assign sync_lock  = lock_q;
    assign bit_err    = err_q;

endmodule

// File: rtl/f2f_bit_recover_chk.sv
// Protocol checks on the outputs of the bit recovery block, attached by bind.
module f2f_bit_recover_chk (
    input logic clk,
    input logic rst_n,
    input logic flux_evt,
    input logic bit_strobe,
    input logic bit_data,
    input logic sync_lock,
    input logic bit_err
);

    // R6: bits are only reported while synchronised
    assert_bit_when_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_strobe |-> sync_lock);

    // R6: data is qualified by the strobe
    assert_data_qualified_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_strobe |-> !bit_data);

    // R8: an error pulse coincides with the loss of lock
    assert_err_drops_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bit_err |-> (!sync_lock && $past(sync_lock)));

    // R3: the cycle that acquires lock reports neither bit nor error
    assert_lock_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_lock) |-> (!bit_strobe && !bit_err));

    // R2: every output event follows an input transition one cycle earlier
    assert_event_caused_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_strobe || bit_err || $rose(sync_lock)) |-> $past(flux_evt));

    // R9: a bit and an error never appear together
    assert_bit_err_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_strobe && bit_err));

endmodule

bind f2f_bit_recover f2f_bit_recover_chk u_chk (
    .clk(clk), .rst_n(rst_n), .flux_evt(flux_evt),
    .bit_strobe(bit_strobe), .bit_data(bit_data),
    .sync_lock(sync_lock), .bit_err(bit_err)
);

// File: tb/f2f_bit_recover_bench.sv
module f2f_bit_recover_bench;

    localparam int SW   = 12;
    localparam int RL   = 3;
    localparam int RUN  = 1 << RL;
    localparam int MASK = (1 << SW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flux_evt = 1'b0;
    logic [SW-1:0] flux_stamp = '0;
    logic          bit_strobe, bit_data, sync_lock, bit_err;

    f2f_bit_recover #(.STAMP_W(SW), .RUN_LOG2(RL)) u_f2f_bit_recover (
        .clk(clk), .rst_n(rst_n), .flux_evt(flux_evt), .flux_stamp(flux_stamp),
        .bit_strobe(bit_strobe), .bit_data(bit_data),
        .sync_lock(sync_lock), .bit_err(bit_err)
    );

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int now = 4000;
    bit done = 0;
    bit started = 0;
    int strobe_cnt = 0;
    int err_cnt = 0;

    // behavioural reference state
    int m_have, m_last, m_cnt, m_sum, m_prev, m_p, m_pend, m_half;
    int e_lock, e_bv, e_val, e_err;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // Reference model: evaluated at each rising edge from the sampled inputs
    always @(posedge clk) begin
        int iv;
        int meas;
        started = 1;
        e_bv = 0; e_val = 0; e_err = 0;
        if (!rst_n) begin
            m_have = 0; m_last = 0; m_cnt = 0; m_sum = 0; m_prev = 0;
            m_p = 0; m_pend = 0; m_half = 0; e_lock = 0;
        end else if (flux_evt) begin
            if (m_have != 0) begin
                iv = (int'(flux_stamp) - m_last) & MASK;
                if (e_lock == 0) begin
                    if (m_cnt > 0 && 4 * iabs(iv - m_prev) <= m_prev) begin
                        m_cnt++; m_sum += iv;
                    end else begin
                        m_cnt = 1; m_sum = iv;
                    end
                    m_prev = iv;
                    if (m_cnt == RUN) begin
                        e_lock = 1; m_p = m_sum / RUN; m_cnt = 0; m_pend = 0;
                    end
                end else begin
                    meas = -1;
                    if (iv > 2 * m_p) begin
                        e_err = 1; e_lock = 0; m_pend = 0;
                    end else if (4 * iv < 3 * m_p) begin
                        if (m_pend != 0) begin
                            e_bv = 1; e_val = 1; meas = m_half + iv; m_pend = 0;
                        end else begin
                            m_pend = 1; m_half = iv;
                        end
                    end else if (m_pend != 0) begin
                        e_err = 1; e_lock = 0; m_pend = 0;
                    end else begin
                        e_bv = 1; meas = iv;
                    end
                    if (meas >= 0) m_p = (m_p + ((meas - m_p) >>> 2)) & MASK;
                end
            end
            m_have = 1;
            m_last = int'(flux_stamp);
        end
    end

    // Compare against the model every cycle, away from the rising edge
    always @(negedge clk) begin
        if (started && !done) begin
            chk("R3 sync_lock", int'(sync_lock), e_lock);
            chk("R6 bit_strobe", int'(bit_strobe), e_bv);
            chk("R6 bit_data", int'(bit_data), e_val);
            chk("R8/R9 bit_err", int'(bit_err), e_err);
            if (bit_strobe) strobe_cnt++;
            if (bit_err) err_cnt++;
        end
    end

    task automatic send(input int d);
        @(negedge clk);
        now = now + d;
        flux_evt = 1'b1;
        flux_stamp = SW'(now & MASK);
        @(negedge clk);
        flux_evt = 1'b0;
    endtask

    task automatic expect_out(input string tag, input int s, input int dv, input int l, input int e);
        chk({tag, " strobe"}, int'(bit_strobe), s);
        chk({tag, " data"}, int'(bit_data), dv);
        chk({tag, " lock"}, int'(sync_lock), l);
        chk({tag, " err"}, int'(bit_err), e);
    endtask

    initial begin
        int c;
        int k;
        int bits;
        int s0;
        int e0;
        repeat (3) @(negedge clk);
        expect_out("R1 in reset", 0, 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out("R1 after reset", 0, 0, 0, 0);

        // R3/R4: leading zeros at 100 counts
        send(0);
        for (int i = 0; i < 7; i++) send(100);
        expect_out("R3 seven intervals", 0, 0, 0, 0);
        send(100);
        expect_out("R3 lock on eighth", 0, 0, 1, 0);

        // R6: zero, then a pair of halves
        send(100);
        expect_out("R6 zero", 1, 0, 1, 0);
        send(50);
        expect_out("R6 first half silent", 0, 0, 1, 0);
        send(50);
        expect_out("R6 one", 1, 1, 1, 0);

        // R5: 4*75 == 3*100 is a full cell
        send(75);
        expect_out("R5 threshold full", 1, 0, 1, 0);
        // R7: P is now 93, so 70 is full and 65 a half
        send(70);
        expect_out("R7 adapted full", 1, 0, 1, 0);
        send(65);
        expect_out("R7 adapted half", 0, 0, 1, 0);
        send(65);
        expect_out("R7 adapted one", 1, 1, 1, 0);

        // R7/R2: speed ramp 97 -> 1000 -> 50 counts, stamps wrap repeatedly
        s0 = strobe_cnt; e0 = err_cnt; bits = 0; k = 0; c = 97;
        while (c < 1000) begin
            if (k % 3 == 0) begin send(c / 2); send(c - c / 2); end
            else send(c);
            bits++; k++; c = c + c / 32;
        end
        while (c > 50) begin
            if (k % 3 == 0) begin send(c / 2); send(c - c / 2); end
            else send(c);
            bits++; k++; c = c - c / 32;
        end
        chk("R7 ramp no error", err_cnt - e0, 0);
        chk("R2 R6 ramp bit count", strobe_cnt - s0, bits);
        chk("R7 ramp still locked", int'(sync_lock), 1);

        // R9: exactly 2P is a zero, 2P+1 faults
        send(2 * m_p);
        expect_out("R9 twice period", 1, 0, 1, 0);
        send(2 * m_p + 1);
        expect_out("R9 too long", 0, 0, 0, 1);

        // R10/R3: relock; 126 breaks the 100 run and starts a new one
        send(100); send(100); send(126);
        for (int i = 0; i < 6; i++) send(126);
        expect_out("R3 broken run", 0, 0, 0, 0);
        send(126);
        expect_out("R10 relock", 0, 0, 1, 0);
        send(95);
        expect_out("R4 period 126", 1, 0, 1, 0);

        // R8: a lone half then a full cell
        send(60);
        expect_out("R8 pending half", 0, 0, 1, 0);
        send(118);
        expect_out("R8 unpaired half", 0, 0, 0, 1);

        // R3/R4: 125 after 100 is near-equal; average floors to 103
        for (int i = 0; i < 3; i++) send(100);
        send(125);
        for (int i = 0; i < 3; i++) send(100);
        expect_out("R3 near run of seven", 0, 0, 0, 0);
        send(100);
        expect_out("R3 near-equal lock", 0, 0, 1, 0);
        send(78);
        expect_out("R4 averaged period", 1, 0, 1, 0);

        repeat (2) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule